// File: doc/BRIEF.md
# Tile Matrix-Multiply Sequencer

This block computes C = C + A×B on small tiles of 32-bit words held in three external synchronous memories. Every dword carries four byte lanes. One multiply step takes one dword from A, one dword from B and one accumulator dword. It multiplies the four lane pairs, adds the four products and adds that sum to the accumulator. Each lane of A and of B can be read as signed or as unsigned.

After a one-cycle start pulse, the block latches the shape of the operation: the number of destination rows, the bytes per destination row and the bytes per A row. It then works through the output rows in order. For each row it does the following:

- It loads the current destination row into an internal row buffer.
- It runs every (k, n) step against that buffer, with k ranging over the A words and n over the destination words.
- It writes the row back. Words past the configured width are written as zero.

When the configured rows are finished, every remaining destination row up to the maximum is written as zero. A one-cycle done pulse then ends the operation. In the same cycle the block pulses an output that tells the surrounding configuration logic to clear its saved start position.

Top module: `tile_mac_seq`

## Requirements
- R1: While reset is held and directly after it, busy, done, origin_clr and every read and write enable are low.
- R2: The dword count of a tile row is its configured byte count divided by four. A word addresses run over [0, src_bytes/4) and B word addresses over [0, dst_bytes/4).
- R3: Multiply steps are issued one per clock in nested order (row m outermost, k middle, n innermost). Each step reads A row m word k and B row k word n. Read data is expected one cycle after the enable. If either dword count is zero, no steps are issued.
- R4: A step adds to accumulator word n the sum of the four byte-lane products of the A and B dwords, modulo 2^32. mode[1]=1 sign-extends the A bytes and mode[1]=0 zero-extends them. mode[0] does the same for the B bytes.
- R5: Each output row starts by reading all 16 dwords of destination row m in ascending word order, one per cycle. Accumulation starts from those values.
- R6: One idle cycle after the last step of a row (or right after the load when there are no steps), the block writes 16 dwords to row m in ascending word order. Words at or past dst_bytes/4 are written as zero.
- R7: After the configured rows, each row from cfg_rows up to 15 receives 16 zero writes in ascending order. With cfg_rows = 0, all rows are cleared.
- R8: done and origin_clr are high together for exactly one cycle, immediately after the final write. The block is idle on the next cycle.
- R9: A start pulse while busy is ignored. The running operation keeps its latched shape and mode.
- R10: busy is high for exactly rows·(32 + S) + (16 − rows)·16 + 1 cycles. S = 0 when there are no steps and K·N + 1 otherwise, with K = src_bytes/4 and N = dst_bytes/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| mode | input | 2 | Bit 1: A bytes signed; bit 0: B bytes signed |
| cfg_rows | input | 5 | Destination rows to compute (0..16) |
| cfg_dst_bytes | input | 7 | Bytes per destination and B row (multiple of 4) |
| cfg_src_bytes | input | 7 | Bytes per A row (multiple of 4) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| origin_clr | output | 1 | One-cycle request to zero the saved start position |
| a_rd_en | output | 1 | A read enable |
| a_rd_row | output | 4 | A row address |
| a_rd_word | output | 4 | A word address |
| a_rd_data | input | 32 | A read data, one cycle after enable |
| b_rd_en | output | 1 | B read enable |
| b_rd_row | output | 4 | B row address |
| b_rd_word | output | 4 | B word address |
| b_rd_data | input | 32 | B read data, one cycle after enable |
| c_rd_en | output | 1 | Destination read enable |
| c_rd_row | output | 4 | Destination read row |
| c_rd_word | output | 4 | Destination read word |
| c_rd_data | input | 32 | Destination read data, one cycle after enable |
| c_wr_en | output | 1 | Destination write enable |
| c_wr_row | output | 4 | Destination write row |
| c_wr_word | output | 4 | Destination write word |
| c_wr_data | output | 32 | Destination write data |

## Verification
A wrong loop counter appears on the A or B address ports in the same cycle it goes wrong. A wrong state transition shows up as an enable that is high or low in the wrong cycle, or as busy ending early or late. A corrupted row-buffer word or a wrong sign choice stays hidden until that row is written back. This can be up to K·N + 17 cycles after the faulty step. The error then shows on c_wr_data for that word, and again when the destination contents are compared at the end. A fault in the upper-row clearing is seen only in the final zero writes and in the done timing.

// File: rtl/tile_mac_pkg.sv
package tile_mac_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_LOAD  = 3'd1,
        S_MAC   = 3'd2,
        S_DRAIN = 3'd3,
        S_WB    = 3'd4,
        S_CLR   = 3'd5,
        S_FIN   = 3'd6
    } seq_st_e;

    localparam int LANE_W = 8;

endpackage

// File: rtl/tile_dot4.sv
module tile_dot4
    import tile_mac_pkg::*;
#(
    parameter int DW = 32,
    localparam int LANES = DW / LANE_W,
    localparam int PW = 2 * LANE_W + 2
) (
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          x_signed,
    input  logic          y_signed,
    output logic [DW-1:0] sum
);

    logic [DW-1:0] prod [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [LANE_W:0] xe;
        logic signed [LANE_W:0] ye;
        logic signed [PW-1:0]   p;
        assign xe = {x_signed & x[i*LANE_W+LANE_W-1], x[i*LANE_W +: LANE_W]};
        assign ye = {y_signed & y[i*LANE_W+LANE_W-1], y[i*LANE_W +: LANE_W]};
        assign p  = PW'(xe) * PW'(ye);
        assign prod[i] = {{(DW-PW){p[PW-1]}}, p};
    end

    always_comb begin
        sum = acc;
        for (int i = 0; i < LANES; i++) begin
            sum = sum + prod[i];
        end
    end

endmodule

// File: rtl/tile_row_buf.sv
module tile_row_buf #(
    parameter int DEPTH = 16,
    parameter int DW = 32,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx_a,
    output logic [DW-1:0] rd_data_a,
    input  logic [IW-1:0] rd_idx_b,
    output logic [DW-1:0] rd_data_b
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data_a = mem_q[rd_idx_a];
    assign rd_data_b = mem_q[rd_idx_b];

endmodule

// File: rtl/tile_mac_seq.sv
module tile_mac_seq
    import tile_mac_pkg::*;
#(
    parameter int MAX_ROWS = 16,
    parameter int MAX_WORDS = 16,
    parameter int DW = 32,
    localparam int ROW_W = $clog2(MAX_ROWS),
    localparam int WORD_W = $clog2(MAX_WORDS),
    localparam int RCNT_W = $clog2(MAX_ROWS + 1),
    localparam int WCNT_W = $clog2(MAX_WORDS + 1),
    localparam int BCNT_W = WCNT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [RCNT_W-1:0] cfg_rows,
    input  logic [BCNT_W-1:0] cfg_dst_bytes,
    input  logic [BCNT_W-1:0] cfg_src_bytes,
    output logic              busy,
    output logic              done,
    output logic              origin_clr,
    output logic              a_rd_en,
    output logic [ROW_W-1:0]  a_rd_row,
    output logic [WORD_W-1:0] a_rd_word,
    input  logic [DW-1:0]     a_rd_data,
    output logic              b_rd_en,
    output logic [WORD_W-1:0] b_rd_row,
    output logic [WORD_W-1:0] b_rd_word,
    input  logic [DW-1:0]     b_rd_data,
    output logic              c_rd_en,
    output logic [ROW_W-1:0]  c_rd_row,
    output logic [WORD_W-1:0] c_rd_word,
    input  logic [DW-1:0]     c_rd_data,
    output logic              c_wr_en,
    output logic [ROW_W-1:0]  c_wr_row,
    output logic [WORD_W-1:0] c_wr_word,
    output logic [DW-1:0]     c_wr_data
);

    localparam logic [WORD_W-1:0] W_LAST = WORD_W'(MAX_WORDS - 1);
    localparam logic [RCNT_W-1:0] R_END  = RCNT_W'(MAX_ROWS);

    typedef struct packed {
        seq_st_e           st;
        logic [RCNT_W-1:0] m;
        logic [WORD_W-1:0] w;
        logic [WORD_W-1:0] k;
        logic [WORD_W-1:0] n;
        logic [RCNT_W-1:0] rows;
        logic [WCNT_W-1:0] kcnt;
        logic [WCNT_W-1:0] ncnt;
        logic              sa;
        logic              sb;
        logic              ld_vld;
        logic [WORD_W-1:0] ld_idx;
        logic              mac_vld;
        logic [WORD_W-1:0] mac_n;
    } seq_t;

    seq_t q, d;

    logic              buf_we;
    logic [WORD_W-1:0] buf_widx;
    logic [DW-1:0]     buf_wdata;
    logic [DW-1:0]     acc_cur;
    logic [DW-1:0]     wb_word;
    logic [DW-1:0]     dot_sum;

    tile_row_buf #(.DEPTH(MAX_WORDS), .DW(DW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_we),
        .wr_idx   (buf_widx),
        .wr_data  (buf_wdata),
        .rd_idx_a (q.mac_n),
        .rd_data_a(acc_cur),
        .rd_idx_b (q.w),
        .rd_data_b(wb_word)
    );

    tile_dot4 #(.DW(DW)) u_dot (
        .acc     (acc_cur),
        .x       (a_rd_data),
        .y       (b_rd_data),
        .x_signed(q.sa),
        .y_signed(q.sb),
        .sum     (dot_sum)
    );

    always_comb begin
        d          = q;
        d.ld_vld   = 1'b0;
        d.mac_vld  = 1'b0;
        busy       = (q.st != S_IDLE);
        done       = 1'b0;
        origin_clr = 1'b0;
        a_rd_en    = 1'b0;
        a_rd_row   = q.m[ROW_W-1:0];
        a_rd_word  = q.k;
        b_rd_en    = 1'b0;
        b_rd_row   = q.k;
        b_rd_word  = q.n;
        c_rd_en    = 1'b0;
        c_rd_row   = q.m[ROW_W-1:0];
        c_rd_word  = q.w;
        c_wr_en    = 1'b0;
        c_wr_row   = q.m[ROW_W-1:0];
        c_wr_word  = q.w;
        c_wr_data  = '0;

        // Row buffer fill: loaded words first, then dot-product results.
        buf_we    = q.ld_vld | q.mac_vld;
        buf_widx  = q.ld_vld ? q.ld_idx : q.mac_n;
        buf_wdata = q.ld_vld ? c_rd_data : dot_sum;

        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.rows = cfg_rows;
                    d.ncnt = cfg_dst_bytes[BCNT_W-1:2];
                    d.kcnt = cfg_src_bytes[BCNT_W-1:2];
                    d.sa   = mode[1];
                    d.sb   = mode[0];
                    d.m    = '0;
                    d.w    = '0;
                    d.k    = '0;
                    d.n    = '0;
                    d.st   = (cfg_rows == '0) ? S_CLR : S_LOAD;
                end
            end
            S_LOAD: begin
                c_rd_en  = 1'b1;
                d.ld_vld = 1'b1;
                d.ld_idx = q.w;
                d.w      = q.w + 1'b1;
                if (q.w == W_LAST) begin
                    d.w  = '0;
                    d.st = (q.kcnt != '0 && q.ncnt != '0) ? S_MAC : S_WB;
                end
            end
            S_MAC: begin
                a_rd_en   = 1'b1;
                b_rd_en   = 1'b1;
                d.mac_vld = 1'b1;
                d.mac_n   = q.n;
                if ((WCNT_W'(q.n) + 1'b1) == q.ncnt) begin
                    d.n = '0;
                    if ((WCNT_W'(q.k) + 1'b1) == q.kcnt) begin
                        d.k  = '0;
                        d.st = S_DRAIN;
                    end else begin
                        d.k = q.k + 1'b1;
                    end
                end else begin
                    d.n = q.n + 1'b1;
                end
            end
            S_DRAIN: begin
                d.st = S_WB;
            end
            S_WB: begin
                c_wr_en   = 1'b1;
                c_wr_data = (WCNT_W'(q.w) < q.ncnt) ? wb_word : '0;
                d.w       = q.w + 1'b1;
                if (q.w == W_LAST) begin
                    d.w = '0;
                    d.m = q.m + 1'b1;
                    if ((q.m + 1'b1) == q.rows) begin
                        d.st = ((q.m + 1'b1) == R_END) ? S_FIN : S_CLR;
                    end else begin
                        d.st = S_LOAD;
                    end
                end
            end
            S_CLR: begin
                c_wr_en = 1'b1;
                d.w     = q.w + 1'b1;
                if (q.w == W_LAST) begin
                    d.w = '0;
                    d.m = q.m + 1'b1;
                    if ((q.m + 1'b1) == R_END) d.st = S_FIN;
                end
            end
            S_FIN: begin
                done       = 1'b1;
                origin_clr = 1'b1;
                d.st       = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr_en && (RCNT_W'(c_wr_row) >= q.rows) |-> c_wr_data == '0);

    // R6
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr_en && (WCNT_W'(c_wr_word) >= q.ncnt) |-> c_wr_data == '0);

    // R2
    word_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_rd_en |-> (WCNT_W'(a_rd_word) < q.kcnt) && (WCNT_W'(b_rd_word) < q.ncnt));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(q.rows) && $stable(q.ncnt) && $stable(q.kcnt) && $stable(q.sa));

    // R6
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_wr_en && c_rd_en) && !(c_wr_en && a_rd_en));

endmodule

// File: tb/tile_mac_seq_tb.sv
module tile_mac_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = '0;
    logic [4:0]  cfg_rows = '0;
    logic [6:0]  cfg_dst_bytes = '0;
    logic [6:0]  cfg_src_bytes = '0;
    logic        busy, done, origin_clr;
    logic        a_rd_en, b_rd_en, c_rd_en, c_wr_en;
    logic [3:0]  a_rd_row, a_rd_word, b_rd_row, b_rd_word;
    logic [3:0]  c_rd_row, c_rd_word, c_wr_row, c_wr_word;
    logic [31:0] a_rd_data, b_rd_data, c_rd_data, c_wr_data;

    logic [31:0] amem [16][16];
    logic [31:0] bmem [16][16];
    logic [31:0] cmem [16][16];
    logic [31:0] exp_c [16][16];

    int checks = 0;
    int errors = 0;
    int seed = 32'h1234567;
    int exp_rows = 0;

    typedef struct packed {
        logic        busy;
        logic        done;
        logic        oclr;
        logic        are;
        logic [3:0]  arow;
        logic [3:0]  aword;
        logic        bre;
        logic [3:0]  brow;
        logic [3:0]  bword;
        logic        cre;
        logic [3:0]  crow;
        logic [3:0]  cword;
        logic        cwe;
        logic [3:0]  cwrow;
        logic [3:0]  cwword;
        logic [31:0] cwdata;
        logic [4:0]  ncnt;
    } rec_t;

    rec_t exp_q[$];

    tile_mac_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .cfg_rows(cfg_rows), .cfg_dst_bytes(cfg_dst_bytes), .cfg_src_bytes(cfg_src_bytes),
        .busy(busy), .done(done), .origin_clr(origin_clr),
        .a_rd_en(a_rd_en), .a_rd_row(a_rd_row), .a_rd_word(a_rd_word), .a_rd_data(a_rd_data),
        .b_rd_en(b_rd_en), .b_rd_row(b_rd_row), .b_rd_word(b_rd_word), .b_rd_data(b_rd_data),
        .c_rd_en(c_rd_en), .c_rd_row(c_rd_row), .c_rd_word(c_rd_word), .c_rd_data(c_rd_data),
        .c_wr_en(c_wr_en), .c_wr_row(c_wr_row), .c_wr_word(c_wr_word), .c_wr_data(c_wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Synchronous memories with one-cycle read latency
    always @(posedge clk) begin
        if (a_rd_en) a_rd_data <= amem[a_rd_row][a_rd_word];
        if (b_rd_en) b_rd_data <= bmem[b_rd_row][b_rd_word];
        if (c_rd_en) c_rd_data <= cmem[c_rd_row][c_rd_word];
        if (c_wr_en) cmem[c_wr_row][c_wr_word] <= c_wr_data;
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] dp(logic [31:0] acc, logic [31:0] x, logic [31:0] y,
                                       bit sx, bit sy);
        int s;
        s = int'(acc);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] xb;
            logic [7:0] yb;
            int xv;
            int yv;
            xb = x[i*8 +: 8];
            yb = y[i*8 +: 8];
            xv = sx ? int'($signed(xb)) : int'(xb);
            yv = sy ? int'($signed(yb)) : int'(yb);
            s = s + xv * yv;
        end
        return 32'(s);
    endfunction

    function automatic logic [31:0] rnd();
        seed = seed * 1103515245 + 12345;
        return 32'(seed) ^ (32'(seed) >> 13);
    endfunction

    task automatic fill(bit extreme);
        for (int r = 0; r < 16; r++) begin
            for (int w = 0; w < 16; w++) begin
                if (extreme) begin
                    amem[r][w] = ((r + w) % 2 == 0) ? 32'h8080_8080 : 32'hFF7F_0180;
                    bmem[r][w] = (w % 2 == 0) ? 32'hFFFF_FFFF : 32'h8001_7F80;
                    cmem[r][w] = 32'h7FFF_FFF0 + 32'(w);
                end else begin
                    amem[r][w] = rnd();
                    bmem[r][w] = rnd();
                    cmem[r][w] = rnd();
                end
            end
        end
    endtask

    // Behavioural reference: expected port trace for one operation
    task automatic build(int rows, int dbytes, int sbytes, logic [1:0] md);
        int nn;
        int kk;
        logic [31:0] tmp [16];
        rec_t r;
        nn = dbytes / 4;
        kk = sbytes / 4;
        exp_q.delete();
        for (int m = 0; m < rows; m++) begin
            for (int w = 0; w < 16; w++) begin
                r = '0; r.busy = 1; r.cre = 1; r.crow = 4'(m); r.cword = 4'(w);
                exp_q.push_back(r);
                tmp[w] = cmem[m][w];
            end
            if (kk > 0 && nn > 0) begin
                for (int k = 0; k < kk; k++) begin
                    for (int n = 0; n < nn; n++) begin
                        r = '0; r.busy = 1;
                        r.are = 1; r.arow = 4'(m); r.aword = 4'(k);
                        r.bre = 1; r.brow = 4'(k); r.bword = 4'(n);
                        exp_q.push_back(r);
                        tmp[n] = dp(tmp[n], amem[m][k], bmem[k][n], md[1], md[0]);
                    end
                end
                r = '0; r.busy = 1;
                exp_q.push_back(r);
            end
            for (int w = 0; w < 16; w++) begin
                r = '0; r.busy = 1; r.cwe = 1; r.cwrow = 4'(m); r.cwword = 4'(w);
                r.cwdata = (w < nn) ? tmp[w] : 32'h0;
                r.ncnt = 5'(nn);
                exp_q.push_back(r);
                exp_c[m][w] = r.cwdata;
            end
        end
        for (int m = rows; m < 16; m++) begin
            for (int w = 0; w < 16; w++) begin
                r = '0; r.busy = 1; r.cwe = 1; r.cwrow = 4'(m); r.cwword = 4'(w);
                r.ncnt = 5'(nn);
                exp_q.push_back(r);
                exp_c[m][w] = 32'h0;
            end
        end
        r = '0; r.busy = 1; r.done = 1; r.oclr = 1;
        exp_q.push_back(r);
        r = '0;
        exp_q.push_back(r);
    endtask

    task automatic cmp(rec_t e);
        chk("R10", "busy", 32'(busy), 32'(e.busy));
        chk("R8", "done", 32'(done), 32'(e.done));
        chk("R8", "origin_clr", 32'(origin_clr), 32'(e.oclr));
        chk("R3", "a_rd_en", 32'(a_rd_en), 32'(e.are));
        chk("R3", "b_rd_en", 32'(b_rd_en), 32'(e.bre));
        if (e.are) begin
            chk("R3", "a_rd_row", 32'(a_rd_row), 32'(e.arow));
            chk("R2", "a_rd_word", 32'(a_rd_word), 32'(e.aword));
            chk("R3", "b_rd_row", 32'(b_rd_row), 32'(e.brow));
            chk("R2", "b_rd_word", 32'(b_rd_word), 32'(e.bword));
        end
        chk("R5", "c_rd_en", 32'(c_rd_en), 32'(e.cre));
        if (e.cre) begin
            chk("R5", "c_rd_row", 32'(c_rd_row), 32'(e.crow));
            chk("R5", "c_rd_word", 32'(c_rd_word), 32'(e.cword));
        end
        chk("R6", "c_wr_en", 32'(c_wr_en), 32'(e.cwe));
        if (e.cwe) begin
            chk("R6", "c_wr_row", 32'(c_wr_row), 32'(e.cwrow));
            chk("R6", "c_wr_word", 32'(c_wr_word), 32'(e.cwword));
            if (32'(e.cwrow) >= 32'(exp_rows))
                chk("R7", "clear data", c_wr_data, e.cwdata);
            else if (32'(e.cwword) >= 32'(e.ncnt))
                chk("R6", "pad data", c_wr_data, e.cwdata);
            else
                chk("R4", "row data", c_wr_data, e.cwdata);
        end
    endtask

    task automatic run(int rows, int dbytes, int sbytes, logic [1:0] md, bit poke);
        int idx;
        build(rows, dbytes, sbytes, md);
        exp_rows = rows;
        @(negedge clk);
        start = 1'b1; mode = md;
        cfg_rows = 5'(rows); cfg_dst_bytes = 7'(dbytes); cfg_src_bytes = 7'(sbytes);
        @(negedge clk);
        start = 1'b0;
        idx = 0;
        while (exp_q.size() > 0) begin
            cmp(exp_q.pop_front());
            if (poke && idx == 5) begin
                // R9: start while busy with a different shape
                start = 1'b1; mode = ~md; cfg_rows = 5'd1;
                cfg_dst_bytes = 7'd4; cfg_src_bytes = 7'd4;
            end else begin
                start = 1'b0;
            end
            idx++;
            @(negedge clk);
        end
        for (int r = 0; r < 16; r++) begin
            for (int w = 0; w < 16; w++) begin
                chk(poke ? "R9" : (r >= rows ? "R7" : "R6"), "final C", cmem[r][w], exp_c[r][w]);
            end
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        a_rd_data = '0; b_rd_data = '0; c_rd_data = '0;
        fill(1'b0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy in reset", 32'(busy), 32'd0);
        chk("R1", "done in reset", 32'(done), 32'd0);
        chk("R1", "enables in reset", 32'({a_rd_en, b_rd_en, c_rd_en, c_wr_en, origin_clr}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", 32'(busy), 32'd0);
        chk("R1", "enables after reset", 32'({a_rd_en, b_rd_en, c_rd_en, c_wr_en, done}), 32'd0);

        run(4, 12, 8, 2'b11, 1'b0);
        run(16, 64, 64, 2'b00, 1'b0);
        fill(1'b0);
        run(16, 64, 64, 2'b01, 1'b0);
        fill(1'b0);
        run(16, 64, 64, 2'b10, 1'b1);
        fill(1'b1);
        run(16, 64, 64, 2'b11, 1'b0);
        fill(1'b1);
        run(16, 64, 64, 2'b00, 1'b0);
        fill(1'b0);
        run(0, 64, 64, 2'b11, 1'b0);
        fill(1'b0);
        run(7, 20, 0, 2'b10, 1'b0);
        fill(1'b0);
        run(5, 4, 64, 2'b01, 1'b0);
        fill(1'b0);
        run(3, 0, 16, 2'b11, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule